// File: doc/BRIEF.md
# Chip Power Mode Controller

This block keeps one 8-bit mode control register on a simple register bus (address, write strobe, write data, combinational read data). From that register and an optional active-low external power-down pin, it works out a single operating state for the chip. The state can be run, full power-down, standby, core-converter power-down, front-end power-down or outputs-enabled. From the state it decodes an enable vector with one bit per power domain. It also drives a bypass control for the signal-processing path and a chip-reset pulse that clears itself.

A bit in the register selects which source rules. When that bit is clear, a 3-bit power field in the register sets the state. When it is set, the pin rules: while the pin is high the chip runs, and while it is low a 2-bit pin-mode field picks the state. A parameter declares whether the pin exists at all. The pin passes through a two-flop synchronizer. The state, domain vector and bypass output are registered.

No data stream passes through the block, so it has no valid/ready interface. Every port is a plain control or status signal, and a register write completes in the cycle its strobe is high.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and right after it, the mode register reads 0x00, `state_o` is run (0), `dom_en_o` is 4'b1111, and `bypass_o` and `chip_rst_o` are 0.
- R2: A write with `reg_addr` equal to `MODE_ADDR` stores `reg_wdata` with bit 4 forced to 0. Reading at `MODE_ADDR` returns the stored value. Reading any other address returns 0x00, and writes to other addresses change nothing.
- R3: When bit 7 is 0, the power field in bits [2:0] sets the state. The mapping is 000 to run (0), 001 to full power-down (1), 010 to standby (2), 100 to core power-down (3) and 101 to front-end power-down (4).
- R4: Power codes 110 and 111, and pin-mode code 10, resolve to run (0), and the written value still reads back unchanged.
- R5: When bit 7 is 1 and the synchronized pin is low, pin-mode bits [6:5] set the state. The mapping is 00 to full power-down (1), 01 to standby (2) and 11 to outputs-enabled (5). The power field has no effect in this case.
- R6: When bit 7 is 1 and the synchronized pin is high, the state is run (0) whatever the power field and pin-mode bits hold.
- R7: With `HAS_EXT_PIN` = 0, bits [7:5] and the pin have no effect, and the power field alone sets the state.
- R8: Writing power code 011 raises `chip_rst_o` for exactly one cycle, starting one edge after the write edge. On that same edge the hardware rewrites bits [2:0] to 000, so a read during the pulse shows 000. Code 011 resolves to run.
- R9: `bypass_o` follows register bit 3.
- R10: `dom_en_o` bits are {outputs, front end, core, clock}. Run gives 1111, full power-down 0000, standby 0001, core power-down 1101, front-end power-down 1011 and outputs-enabled 1001.
- R11: A register write shows at `state_o`, `dom_en_o` and `bypass_o` after the second rising edge, counting the write edge as the first. A pin change shows after the third rising edge following the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from `reg_addr`) |
| ext_pd_n | input | 1 | External power-down pin, active low, asynchronous |
| state_o | output | 3 | Resolved operating state code |
| dom_en_o | output | 4 | Per-domain enable vector |
| bypass_o | output | 1 | Signal-processing bypass control |
| chip_rst_o | output | 1 | Self-clearing chip-reset pulse |

## Verification
The hardest case to reach from the ports is how the pin interacts with the register. The pin only counts when bit 7 is set. The pin also arrives three edges late, so a check that samples too early sees the register's old decision. The stimulus drives random register values together with random pin levels and waits out the full latency before checking each one. Directed steps then sample the edge just before and the edge just after each expected change. A second instance with no pin receives the same traffic, to show that bits [7:5] have no effect there. The self-clearing reset is checked on the exact cycle of its pulse.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  localparam int DATA_W = 8;
  localparam int DOM_W  = 4;
  localparam int STATE_W = 3;

  localparam int BIT_PIN_EN  = 7;
  localparam int BIT_PM_HI   = 6;
  localparam int BIT_PM_LO   = 5;
  localparam int BIT_RSV     = 4;
  localparam int BIT_BYPASS  = 3;
  localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(1) << BIT_RSV;

  localparam logic [2:0] PF_RUN   = 3'b000;
  localparam logic [2:0] PF_FULL  = 3'b001;
  localparam logic [2:0] PF_STBY  = 3'b010;
  localparam logic [2:0] PF_RESET = 3'b011;
  localparam logic [2:0] PF_CORE  = 3'b100;
  localparam logic [2:0] PF_FE    = 3'b101;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN     = 3'd0,
    ST_FULL_PD = 3'd1,
    ST_STBY    = 3'd2,
    ST_CORE_PD = 3'd3,
    ST_FE_PD   = 3'd4,
    ST_OUT_EN  = 3'd5
  } pwr_state_e;

  // domain bit order: [3] outputs, [2] front end, [1] core, [0] clock
  function automatic logic [DOM_W-1:0] dom_decode(pwr_state_e s);
    case (s)
      ST_RUN:     return 4'b1111;
      ST_FULL_PD: return 4'b0000;
      ST_STBY:    return 4'b0001;
      ST_CORE_PD: return 4'b1101;
      ST_FE_PD:   return 4'b1011;
      ST_OUT_EN:  return 4'b1001;
      default:    return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pwr_pin_sync.sv
`timescale 1ns/1ps
module pwr_pin_sync #(
  parameter bit HAS_PIN = 1'b1,
  parameter int STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic pin_n_o
);
  generate
    if (HAS_PIN) begin : g_sync
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], pin_n_i};
      end
      assign pin_n_o = sr[STAGES-1];
    end else begin : g_none
      logic unused_pin;
      assign unused_pin = pin_n_i;
      assign pin_n_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pwr_mode_reg.sv
`timescale 1ns/1ps
module pwr_mode_reg
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] mode_q,
  output logic              rst_pulse_o
);
  logic hit;
  logic reset_cmd;

  assign hit       = (reg_addr == MODE_ADDR);
  assign reset_cmd = (mode_q[2:0] == PF_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      rst_pulse_o <= 1'b0;
    end else begin
      rst_pulse_o <= reset_cmd && !rst_pulse_o;
      if (reg_wr && hit)
        mode_q <= reg_wdata & ~RSV_MASK;
      else if (reset_cmd)
        mode_q[2:0] <= PF_RUN;
    end
  end

  assign reg_rdata = hit ? mode_q : '0;
endmodule

// File: rtl/pwr_state_resolve.sv
`timescale 1ns/1ps
module pwr_state_resolve
  import pwr_pkg::*;
#(
  parameter bit HAS_PIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mode_q,
  input  logic              pin_n,
  output logic [STATE_W-1:0] state_o,
  output logic [DOM_W-1:0]   dom_en_o,
  output logic               bypass_o
);
  pwr_state_e reg_state, pin_state, next_state;
  logic pin_rules;

  always_comb begin
    case (mode_q[2:0])
      PF_FULL: reg_state = ST_FULL_PD;
      PF_STBY: reg_state = ST_STBY;
      PF_CORE: reg_state = ST_CORE_PD;
      PF_FE:   reg_state = ST_FE_PD;
      default: reg_state = ST_RUN;
    endcase
  end

  always_comb begin
    case (mode_q[BIT_PM_HI:BIT_PM_LO])
      2'b00:   pin_state = ST_FULL_PD;
      2'b01:   pin_state = ST_STBY;
      2'b11:   pin_state = ST_OUT_EN;
      default: pin_state = ST_RUN;
    endcase
  end

  assign pin_rules = HAS_PIN && mode_q[BIT_PIN_EN];

  always_comb begin
    if (!pin_rules)  next_state = reg_state;
    else if (pin_n)  next_state = ST_RUN;
    else             next_state = pin_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o  <= ST_RUN;
      dom_en_o <= dom_decode(ST_RUN);
      bypass_o <= 1'b0;
    end else begin
      state_o  <= next_state;
      dom_en_o <= dom_decode(next_state);
      bypass_o <= mode_q[BIT_BYPASS];
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl #(
  parameter bit HAS_EXT_PIN = 1'b1,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h08,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ext_pd_n,
  output logic [2:0]        state_o,
  output logic [3:0]        dom_en_o,
  output logic              bypass_o,
  output logic              chip_rst_o
);
  logic [7:0] mode_q;
  logic       pin_n_s;

  pwr_pin_sync #(.HAS_PIN(HAS_EXT_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n_i(ext_pd_n), .pin_n_o(pin_n_s)
  );

  pwr_mode_reg #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_q(mode_q),
    .rst_pulse_o(chip_rst_o)
  );

  pwr_state_resolve #(.HAS_PIN(HAS_EXT_PIN)) u_res (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .pin_n(pin_n_s),
    .state_o(state_o), .dom_en_o(dom_en_o), .bypass_o(bypass_o)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        mode_q,
  input logic [2:0]        state_o,
  input logic [3:0]        dom_en_o,
  input logic              chip_rst_o
);
  logic wr_hit;
  assign wr_hit = reg_wr && (reg_addr == MODE_ADDR);

  AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_o |=> !chip_rst_o); // R8
  AST_RST_FIELD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst_o && !$past(wr_hit)) |-> (mode_q[2:0] == 3'b000)); // R8
  AST_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[4] == 1'b0); // R2
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5); // R3
  AST_DOM_FULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |-> (dom_en_o == 4'b0000)); // R10
  AST_DOM_RUN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (dom_en_o == 4'b1111)); // R10
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .mode_q(mode_q), .state_o(state_o), .dom_en_o(dom_en_o), .chip_rst_o(chip_rst_o)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam logic [7:0] MA = 8'h08;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = MA;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       ext_pd_n = 1'b1;
  logic [7:0] rd_a, rd_b;
  logic [2:0] st_a, st_b;
  logic [3:0] dom_a, dom_b;
  logic       byp_a, byp_b, crst_a, crst_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.HAS_EXT_PIN(1'b1)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_a), .ext_pd_n(ext_pd_n),
    .state_o(st_a), .dom_en_o(dom_a), .bypass_o(byp_a), .chip_rst_o(crst_a));

  pwr_mode_ctrl #(.HAS_EXT_PIN(1'b0)) u_pwr_mode_ctrl_np (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_b), .ext_pd_n(ext_pd_n),
    .state_o(st_b), .dom_en_o(dom_b), .bypass_o(byp_b), .chip_rst_o(crst_b));

  function automatic logic [7:0] exp_mode(logic [7:0] d);
    logic [7:0] m = d & 8'hEF;
    if (m[2:0] == 3'b011) m[2:0] = 3'b000;
    return m;
  endfunction

  function automatic int exp_state(logic [7:0] m, logic pin_n, bit has_pin);
    if (has_pin && m[7]) begin
      if (pin_n) return 0;
      case (m[6:5]) 2'b00: return 1; 2'b01: return 2; 2'b11: return 5; default: return 0; endcase
    end
    case (m[2:0])
      3'b001: return 1; 3'b010: return 2; 3'b100: return 3; 3'b101: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_dom(int s);
    case (s)
      1: return 4'b0000; 2: return 4'b0001; 3: return 4'b1101;
      4: return 4'b1011; 5: return 4'b1001; default: return 4'b1111;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = MA;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(string req, logic [7:0] m, logic pin_n);
    int sa = exp_state(m, pin_n, 1'b1);
    int sb = exp_state(m, pin_n, 1'b0);
    chk({req, " rdata"}, rd_a, m);
    chk({req, " state"}, st_a, sa);
    chk({req, " dom R10"}, dom_a, exp_dom(sa));
    chk({req, " bypass R9"}, byp_a, m[3]);
    chk({req, " nopin state R7"}, st_b, sb);
    chk({req, " nopin dom R7"}, dom_b, exp_dom(sb));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(3);
    // R1 reset state
    chk("R1 rdata", rd_a, 8'h00);
    chk("R1 state", st_a, 0);
    chk("R1 dom", dom_a, 4'hF);
    chk("R1 bypass", byp_a, 0);
    chk("R1 chip_rst", crst_a, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 reserved bit and other address
    wr(MA, 8'h17); idle(2);
    chk("R2 bit4 dropped", rd_a, 8'h07);
    chk("R4 reserved power code runs", st_a, 0);
    wr(MA + 8'h1, 8'h02); idle(2);
    chk("R2 other addr write ignored", rd_a, 8'h07);
    reg_addr = MA + 8'h1; #1;
    chk("R2 other addr reads zero", rd_a, 8'h00);
    reg_addr = MA;

    // R3 power field decode, also R11 write latency
    for (int c = 0; c < 6; c++) begin
      if (c == 3) continue;
      wr(MA, 8'(c));
      chk("R11 state not yet updated", st_a, c == 0 ? 0 : exp_state(8'(c - (c == 4 ? 2 : 1)), 1'b1, 1'b1));
      @(negedge clk);
      check_all("R3", 8'(c), 1'b1);
    end
    wr(MA, 8'h06); idle(2);
    check_all("R4 code 110", 8'h06, 1'b1);

    // R8 self-clearing reset
    wr(MA, 8'h0B);
    chk("R8 readback 011 before pulse", rd_a, 8'h0B);
    chk("R8 no pulse yet", crst_a, 0);
    @(negedge clk);
    chk("R8 pulse high", crst_a, 1);
    chk("R8 field cleared", rd_a, 8'h08);
    @(negedge clk);
    chk("R8 pulse ended", crst_a, 0);
    chk("R8 state run", st_a, 0);
    chk("R9 bypass set", byp_a, 1);

    // R5/R6 pin control, R11 pin latency
    wr(MA, 8'hE4); idle(2);
    check_all("R6 pin high", 8'hE4, 1'b1);
    @(negedge clk); ext_pd_n = 1'b0;
    idle(2);
    chk("R11 pin not yet seen", st_a, 0);
    @(negedge clk);
    chk("R11 R5 pin mode 11", st_a, 5);
    check_all("R5", 8'hE4, 1'b0);
    wr(MA, 8'h84); idle(2); check_all("R5 pm00", 8'h84, 1'b0);
    wr(MA, 8'hA4); idle(2); check_all("R5 pm01", 8'hA4, 1'b0);
    wr(MA, 8'hC4); idle(2); check_all("R4 pm10", 8'hC4, 1'b0);
    @(negedge clk); ext_pd_n = 1'b1; idle(4);
    check_all("R6 pin released", 8'hC4, 1'b1);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d = 8'($urandom);
      logic p = 1'($urandom);
      if (($urandom % 4) == 0) d[2:0] = 3'b011;
      @(negedge clk); ext_pd_n = p;
      wr(MA, d); idle(4);
      check_all("R3 R5 R6 random", exp_mode(d), p);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule